// File: doc/BRIEF.md
# Frame-Aligned Transcoder Mode Router

This block sits between the serial capture logic of a four-channel voice transcoder and its arithmetic core. It takes one frame's worth of captured data per frame boundary: four PCM octets, one 16-bit ADPCM line word, and the results the codec core produced for the previous frame. Two independent 3-bit mode words are sampled at the same boundary. One governs the encode direction (PCM to ADPCM) and the other governs the decode direction (ADPCM to PCM). All four channels of a direction share that direction's word.

Each frame follows the same schedule. The captured data is handed to the core, processed in the next frame, and then routed to the output registers. That routing either takes the core's result or passes raw bits straight through. Every path is therefore exactly two frames long, bypass paths included. The block also produces per-direction output enables and a per-direction algorithm-reset request for the core.

The data interface is stream-shaped, but it cannot be stalled, because frames arrive at a fixed rate. `frame_strb` acts as the input valid: all data inputs are taken on the cycle it is high. `out_valid` pulses for one cycle when new output words appear. There is no ready signal and no back-pressure, so the consumer must take each output word within one frame, before the next strobe replaces it.

Top module: `xcode_frame_router`

## Requirements
- R1: After reset and before any output frame: `out_valid`=0, all outputs and enables are 0, both reset requests are 0, and `core_pcm`/`core_adpcm` are 0.
- R2: The mode words and `slot_sel` are sampled only on a cycle with `frame_strb`=1. Changes on any other cycle do not affect any output.
- R3: Data taken at strobe k appears on `core_pcm`/`core_adpcm` from the cycle after strobe k. The outputs derived from it appear, with `out_valid`=1 for that one cycle, in the cycle after strobe k+1. This uses the mode words and `slot_sel` latched at strobe k and the core results presented at strobe k+1. Outputs then hold until the next strobe.
- R4: Encode mode 000 (32k) and 001 (24k): channel i's nibble is bits [15-4i:12-4i] of `enc_res`, placed at the same position of `adpcm_out`. In 24k the nibble's LSB is driven 0. `adpcm_oe`=11.
- R5: Encode mode 010 (16k): the top two bits of each `enc_res` nibble are packed into one octet, channel 0 in the MSBs. With `slot_sel`=0 this octet goes to `adpcm_out[15:8]` and `adpcm_oe`=10. With `slot_sel`=1 it goes to `[7:0]` and `adpcm_oe`=01. The unused octet is 0.
- R6: Mode 011 (nibble bypass): in the encode direction, each nibble is the top nibble of the matching PCM octet. In the decode direction, each PCM octet is {nibble, 0000}. All enables are on and `slot_sel` has no effect.
- R7: Mode 100 (2-bit bypass): the encode direction packs bits [7:6] of each PCM octet as in R5. The decode direction takes the 2-bit symbol i from the selected octet (bits [7-2i:6-2i]) into bits [7:6] of PCM octet i, with the other bits 0 and all four PCM enables on.
- R8: Mode 101 (PCM bypass): with `slot_sel`=0, PCM octets 0,1 map to ADPCM octets [15:8],[7:0] and back, giving `pcm_oe`=0011. With `slot_sel`=1, octets 2,3 are used, giving `pcm_oe`=1100. `adpcm_oe`=11.
- R9: Mode 111: the outputs and enables of that direction are 0. The other direction and the core handoff are unaffected.
- R10: Mode 110 makes `enc_rst_req` (encode) or `dec_rst_req` (decode) 1 from the cycle after the strobe that latched it until a strobe latches another code. Its data path behaves like 000 for encode and like R11 for decode.
- R11: Decode modes 000, 001, 010, 110 output `dec_res` unchanged with `pcm_oe`=1111. PCM octet i is at bits [31-8i:24-8i].
- R12: Alternating 000 and 001 from one frame to the next makes each output frame follow the code latched for that frame, with no lost or repeated frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_strb | input | 1 | Frame boundary; input valid for all data and modes |
| enc_mode | input | 3 | Encode-direction mode code |
| dec_mode | input | 3 | Decode-direction mode code |
| slot_sel | input | 1 | Slot / channel-pair select |
| pcm_in | input | 32 | Captured PCM octets, channel 0 in MSBs |
| adpcm_in | input | 16 | Captured ADPCM line word |
| enc_res | input | 16 | Core encode results, 4 nibbles |
| dec_res | input | 32 | Core decode results, 4 octets |
| out_valid | output | 1 | One-cycle pulse on new output words |
| pcm_out | output | 32 | Outgoing PCM octets |
| pcm_oe | output | 4 | Per-channel PCM enable, bit i = channel i |
| adpcm_out | output | 16 | Outgoing ADPCM line word |
| adpcm_oe | output | 2 | Bit 1 enables [15:8], bit 0 enables [7:0] |
| core_pcm | output | 32 | Captured PCM handed to the core |
| core_adpcm | output | 16 | Captured ADPCM handed to the core |
| enc_rst_req | output | 1 | Encode algorithm-reset request |
| dec_rst_req | output | 1 | Decode algorithm-reset request |

## Verification
Three results follow each strobe, each at its own distance. The core handoff and reset requests change in the first cycle after the strobe that took the data. The routed outputs and `out_valid` change one cycle after the following strobe, and the outputs then hold for the whole frame. The bench drives inputs on the falling edge. At the next falling edge it compares every output against a frame-level model, which stores the previous frame's capture and modes and is advanced only when a strobe is driven. Each result is therefore checked exactly in the cycle it becomes due and in every cycle it must hold.

// File: rtl/xcode_route_pkg.sv
package xcode_route_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    M_R32     = 3'd0,
    M_R24     = 3'd1,
    M_R16     = 3'd2,
    M_BYP_NIB = 3'd3,
    M_BYP_SYM = 3'd4,
    M_BYP_PCM = 3'd5,
    M_ALG_RST = 3'd6,
    M_OFF     = 3'd7
  } mode_e;

  // Routing controls derived from one mode code.
  typedef struct packed {
    logic raw;       // take captured bits instead of core result
    logic narrow;    // 2-bit symbols packed into one slot
    logic pcm_pass;  // whole octets between PCM pair and ADPCM line
    logic trunc;     // clear nibble LSB
    logic off;       // direction tristated
    logic alg_rst;   // request algorithm reset
  } route_t;

endpackage

// File: rtl/xr_mode_decode.sv
module xr_mode_decode
  import xcode_route_pkg::*;
(
  input  mode_e  code,
  output route_t rt
);
  always_comb begin
    rt = '0;
    case (code)
      M_R32:     rt = '0;
      M_R24:     rt.trunc = 1'b1;
      M_R16:     rt.narrow = 1'b1;
      M_BYP_NIB: rt.raw = 1'b1;
      M_BYP_SYM: begin rt.raw = 1'b1; rt.narrow = 1'b1; end
      M_BYP_PCM: rt.pcm_pass = 1'b1;
      M_ALG_RST: rt.alg_rst = 1'b1;
      M_OFF:     rt.off = 1'b1;
      default:   rt = '0;
    endcase
  end
endmodule

// File: rtl/xr_enc_route.sv
module xr_enc_route
  import xcode_route_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int OCT_W = 8,
  parameter int NIB_W = 4
) (
  input  route_t                 rt,
  input  logic                   sel,
  input  logic [NCH*OCT_W-1:0]   pcm_cap,
  input  logic [NCH*NIB_W-1:0]   enc_res,
  output logic [NCH*NIB_W-1:0]   adp_word,
  output logic [NCH*NIB_W/OCT_W-1:0] adp_oe
);
  localparam int PCM_W  = NCH * OCT_W;
  localparam int ADP_W  = NCH * NIB_W;
  localparam int SLOT_N = ADP_W / OCT_W;
  localparam int SYM_W  = OCT_W / NCH;

  logic [ADP_W-1:0] nib_word;
  logic [ADP_W-1:0] pass_word;
  logic [OCT_W-1:0] nar_oct;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [NIB_W-1:0] raw_nib, res_nib, nib;
    assign raw_nib = pcm_cap[PCM_W-1-i*OCT_W -: NIB_W];
    assign res_nib = enc_res[ADP_W-1-i*NIB_W -: NIB_W];
    assign nib = (rt.raw ? raw_nib : res_nib) & ~{{(NIB_W-1){1'b0}}, rt.trunc};
    assign nib_word[ADP_W-1-i*NIB_W -: NIB_W] = nib;
    assign nar_oct[OCT_W-1-i*SYM_W -: SYM_W]  = nib[NIB_W-1 -: SYM_W];
  end

  for (genvar j = 0; j < SLOT_N; j++) begin : g_slot
    assign pass_word[ADP_W-1-j*OCT_W -: OCT_W] =
      sel ? pcm_cap[PCM_W-1-(SLOT_N+j)*OCT_W -: OCT_W]
          : pcm_cap[PCM_W-1-j*OCT_W -: OCT_W];
  end

  always_comb begin
    adp_word = '0;
    adp_oe   = '0;
    if (rt.off) begin
      adp_word = '0;
    end else if (rt.pcm_pass) begin
      adp_word = pass_word;
      adp_oe   = '1;
    end else if (rt.narrow) begin
      for (int j = 0; j < SLOT_N; j++) begin
        if (j == int'(sel)) begin
          adp_word[ADP_W-1-j*OCT_W -: OCT_W] = nar_oct;
          adp_oe[SLOT_N-1-j] = 1'b1;
        end
      end
    end else begin
      adp_word = nib_word;
      adp_oe   = '1;
    end
  end
endmodule

// File: rtl/xr_dec_route.sv
module xr_dec_route
  import xcode_route_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int OCT_W = 8,
  parameter int NIB_W = 4
) (
  input  route_t                 rt,
  input  logic                   sel,
  input  logic [NCH*NIB_W-1:0]   adp_cap,
  input  logic [NCH*OCT_W-1:0]   dec_res,
  output logic [NCH*OCT_W-1:0]   pcm_word,
  output logic [NCH-1:0]         pcm_oe
);
  localparam int PCM_W  = NCH * OCT_W;
  localparam int ADP_W  = NCH * NIB_W;
  localparam int SLOT_N = ADP_W / OCT_W;
  localparam int SYM_W  = OCT_W / NCH;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int GRP = i / SLOT_N;
    localparam int POS = i % SLOT_N;
    logic [OCT_W-1:0] res_oct, pass_oct, oct;
    logic [NIB_W-1:0] nib;
    logic [SYM_W-1:0] sym;
    logic             in_grp, en;

    assign res_oct  = dec_res[PCM_W-1-i*OCT_W -: OCT_W];
    assign pass_oct = adp_cap[ADP_W-1-POS*OCT_W -: OCT_W];
    assign nib      = adp_cap[ADP_W-1-i*NIB_W -: NIB_W];
    assign sym      = sel ? adp_cap[OCT_W-1-i*SYM_W -: SYM_W]
                          : adp_cap[ADP_W-1-i*SYM_W -: SYM_W];
    assign in_grp   = (int'(sel) == GRP);

    always_comb begin
      oct = '0;
      en  = 1'b0;
      if (rt.off) begin
        oct = '0;
      end else if (rt.pcm_pass) begin
        oct = in_grp ? pass_oct : '0;
        en  = in_grp;
      end else if (rt.raw && rt.narrow) begin
        oct = {sym, {(OCT_W-SYM_W){1'b0}}};
        en  = 1'b1;
      end else if (rt.raw) begin
        oct = {nib, {(OCT_W-NIB_W){1'b0}}};
        en  = 1'b1;
      end else begin
        oct = res_oct;
        en  = 1'b1;
      end
    end

    assign pcm_word[PCM_W-1-i*OCT_W -: OCT_W] = oct;
    assign pcm_oe[i] = en;
  end
endmodule

// File: rtl/xcode_frame_router.sv
module xcode_frame_router
  import xcode_route_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int OCT_W = 8,
  parameter int NIB_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_strb,
  input  logic [2:0]             enc_mode,
  input  logic [2:0]             dec_mode,
  input  logic                   slot_sel,
  input  logic [NCH*OCT_W-1:0]   pcm_in,
  input  logic [NCH*NIB_W-1:0]   adpcm_in,
  input  logic [NCH*NIB_W-1:0]   enc_res,
  input  logic [NCH*OCT_W-1:0]   dec_res,
  output logic                   out_valid,
  output logic [NCH*OCT_W-1:0]   pcm_out,
  output logic [NCH-1:0]         pcm_oe,
  output logic [NCH*NIB_W-1:0]   adpcm_out,
  output logic [NCH*NIB_W/OCT_W-1:0] adpcm_oe,
  output logic [NCH*OCT_W-1:0]   core_pcm,
  output logic [NCH*NIB_W-1:0]   core_adpcm,
  output logic                   enc_rst_req,
  output logic                   dec_rst_req
);
  localparam int PCM_W  = NCH * OCT_W;
  localparam int ADP_W  = NCH * NIB_W;
  localparam int SLOT_N = ADP_W / OCT_W;

  // Stage 1: per-frame capture and mode latch
  mode_e             enc_mode_q, dec_mode_q;
  logic              sel_q;
  logic [PCM_W-1:0]  cap_pcm_q;
  logic [ADP_W-1:0]  cap_adp_q;
  logic              s1_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_mode_q <= M_OFF;
      dec_mode_q <= M_OFF;
      sel_q      <= 1'b0;
      cap_pcm_q  <= '0;
      cap_adp_q  <= '0;
      s1_vld     <= 1'b0;
    end else if (frame_strb) begin
      enc_mode_q <= mode_e'(enc_mode);
      dec_mode_q <= mode_e'(dec_mode);
      sel_q      <= slot_sel;
      cap_pcm_q  <= pcm_in;
      cap_adp_q  <= adpcm_in;
      s1_vld     <= 1'b1;
    end
  end

  assign core_pcm   = cap_pcm_q;
  assign core_adpcm = cap_adp_q;

  route_t enc_rt, dec_rt;

  xr_mode_decode u_enc_dec (.code(enc_mode_q), .rt(enc_rt));
  xr_mode_decode u_dec_dec (.code(dec_mode_q), .rt(dec_rt));

  assign enc_rst_req = enc_rt.alg_rst;
  assign dec_rst_req = dec_rt.alg_rst;

  logic [ADP_W-1:0]  enc_word;
  logic [SLOT_N-1:0] enc_oe;
  logic [PCM_W-1:0]  dec_word;
  logic [NCH-1:0]    dec_oe;

  xr_enc_route #(.NCH(NCH), .OCT_W(OCT_W), .NIB_W(NIB_W)) u_enc_route (
    .rt(enc_rt), .sel(sel_q), .pcm_cap(cap_pcm_q), .enc_res(enc_res),
    .adp_word(enc_word), .adp_oe(enc_oe)
  );

  xr_dec_route #(.NCH(NCH), .OCT_W(OCT_W), .NIB_W(NIB_W)) u_dec_route (
    .rt(dec_rt), .sel(sel_q), .adp_cap(cap_adp_q), .dec_res(dec_res),
    .pcm_word(dec_word), .pcm_oe(dec_oe)
  );

  // Stage 2: output registers, loaded at the strobe closing the processing frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      pcm_out   <= '0;
      pcm_oe    <= '0;
      adpcm_out <= '0;
      adpcm_oe  <= '0;
    end else begin
      out_valid <= frame_strb & s1_vld;
      if (frame_strb && s1_vld) begin
        pcm_out   <= dec_word;
        pcm_oe    <= dec_oe;
        adpcm_out <= enc_word;
        adpcm_oe  <= enc_oe;
      end
    end
  end

  // Assertions
  p_valid_after_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(frame_strb));

  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_strb |=> ($stable(pcm_out) && $stable(adpcm_out) &&
                     $stable(pcm_oe) && $stable(adpcm_oe)));

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_strb |=> ($stable(enc_mode_q) && $stable(dec_mode_q) && $stable(sel_q)));

  p_rst_req_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(enc_rst_req) || $rose(dec_rst_req)) |-> $past(frame_strb));

  p_enc_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(enc_mode_q) == M_OFF) |-> (adpcm_oe == '0 && adpcm_out == '0));

  p_pcm_pass_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(dec_mode_q) == M_BYP_PCM) |-> ($countones(pcm_oe) == SLOT_N));

  p_narrow_one_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($past(enc_mode_q) == M_R16 || $past(enc_mode_q) == M_BYP_SYM))
      |-> ($countones(adpcm_oe) == 1));

endmodule

// File: tb/xcode_frame_router_tb.sv
module xcode_frame_router_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_strb = 1'b0;
  logic [2:0]  enc_mode = 3'd0, dec_mode = 3'd0;
  logic        slot_sel = 1'b0;
  logic [31:0] pcm_in = '0, dec_res = '0;
  logic [15:0] adpcm_in = '0, enc_res = '0;
  logic        out_valid, enc_rst_req, dec_rst_req;
  logic [31:0] pcm_out, core_pcm;
  logic [3:0]  pcm_oe;
  logic [15:0] adpcm_out, core_adpcm;
  logic [1:0]  adpcm_oe;

  always #4 clk = ~clk;

  xcode_frame_router u_dut (
    .clk(clk), .rst_n(rst_n), .frame_strb(frame_strb),
    .enc_mode(enc_mode), .dec_mode(dec_mode), .slot_sel(slot_sel),
    .pcm_in(pcm_in), .adpcm_in(adpcm_in), .enc_res(enc_res), .dec_res(dec_res),
    .out_valid(out_valid), .pcm_out(pcm_out), .pcm_oe(pcm_oe),
    .adpcm_out(adpcm_out), .adpcm_oe(adpcm_oe),
    .core_pcm(core_pcm), .core_adpcm(core_adpcm),
    .enc_rst_req(enc_rst_req), .dec_rst_req(dec_rst_req)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // frame-level reference state
  bit          have_prev = 0;
  int          prev_em, prev_dm, prev_sel;
  logic [31:0] prev_pcm;
  logic [15:0] prev_adp;
  logic        exp_valid = 0, exp_erst = 0, exp_drst = 0;
  logic [31:0] exp_pcm = '0, exp_core_pcm = '0;
  logic [3:0]  exp_pcm_oe = '0;
  logic [15:0] exp_adp = '0, exp_core_adp = '0;
  logic [1:0]  exp_adp_oe = '0;
  string       etag = "R1", dtag = "R1", phase_tag = "";
  string       etbl[8] = '{"R4", "R4", "R5", "R6", "R7", "R8", "R10", "R9"};
  string       dtbl[8] = '{"R11", "R11", "R11", "R6", "R7", "R8", "R10", "R9"};

  function automatic void enc_ref(input int m, input int s, input logic [31:0] pcm,
                                  input logic [15:0] res, output logic [15:0] w,
                                  output logic [1:0] oe);
    int src, acc;
    w = '0; oe = '0; acc = 0;
    if (m == 7) return;
    if (m == 5) begin
      w = (s != 0) ? pcm[15:0] : pcm[31:16];
      oe = 2'b11;
      return;
    end
    for (int i = 0; i < 4; i++) begin
      if (m == 3 || m == 4) src = int'((pcm >> (28 - 8*i)) & 32'hF);
      else                  src = int'((res >> (12 - 4*i)) & 16'hF);
      if (m == 1) src = src & 14;
      if (m == 2 || m == 4) acc = acc | ((src >> 2) << (6 - 2*i));
      else                  acc = acc | (src << (12 - 4*i));
    end
    if (m == 2 || m == 4) begin
      w  = (s != 0) ? 16'(acc) : 16'(acc << 8);
      oe = (s != 0) ? 2'b01 : 2'b10;
    end else begin
      w  = 16'(acc);
      oe = 2'b11;
    end
  endfunction

  function automatic void dec_ref(input int m, input int s, input logic [15:0] adp,
                                  input logic [31:0] res, output logic [31:0] p,
                                  output logic [3:0] oe);
    int oct, slot;
    p = '0; oe = '0;
    if (m == 7) return;
    if (m == 5) begin
      if (s == 0) begin p = {adp, 16'h0}; oe = 4'b0011; end
      else        begin p = {16'h0, adp}; oe = 4'b1100; end
      return;
    end
    slot = (s != 0) ? int'(adp[7:0]) : int'(adp[15:8]);
    for (int i = 0; i < 4; i++) begin
      if (m == 3)      oct = int'((adp >> (12 - 4*i)) & 16'hF) << 4;
      else if (m == 4) oct = ((slot >> (6 - 2*i)) & 3) << 6;
      else             oct = int'((res >> (24 - 8*i)) & 32'hFF);
      p = p | (32'(oct) << (24 - 8*i));
    end
    oe = 4'b1111;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    string te, td, tv, tr;
    te = etag; td = dtag; tv = "R3"; tr = "R10";
    if (phase_tag != "") begin te = phase_tag; td = phase_tag; tv = phase_tag; tr = phase_tag; end
    chk(tv, "out_valid", 32'(out_valid), 32'(exp_valid));
    chk(tv, "core_pcm", core_pcm, exp_core_pcm);
    chk(tv, "core_adpcm", 32'(core_adpcm), 32'(exp_core_adp));
    chk(tr, "enc_rst_req", 32'(enc_rst_req), 32'(exp_erst));
    chk(tr, "dec_rst_req", 32'(dec_rst_req), 32'(exp_drst));
    chk(te, "adpcm_out", 32'(adpcm_out), 32'(exp_adp));
    chk(te, "adpcm_oe", 32'(adpcm_oe), 32'(exp_adp_oe));
    chk(td, "pcm_out", pcm_out, exp_pcm);
    chk(td, "pcm_oe", 32'(pcm_oe), 32'(exp_pcm_oe));
  endtask

  task automatic drive(input bit strobe, input int em, input int dm, input int s, input bit jitter);
    frame_strb = strobe;
    pcm_in   = $urandom;
    adpcm_in = 16'($urandom);
    enc_res  = 16'($urandom);
    dec_res  = $urandom;
    if (strobe) begin
      enc_mode = 3'(em); dec_mode = 3'(dm); slot_sel = 1'(s);
    end else if (jitter) begin
      enc_mode = 3'($urandom); dec_mode = 3'($urandom); slot_sel = 1'($urandom);
    end
    if (strobe) begin
      if (have_prev) begin
        enc_ref(prev_em, prev_sel, prev_pcm, enc_res, exp_adp, exp_adp_oe);
        dec_ref(prev_dm, prev_sel, prev_adp, dec_res, exp_pcm, exp_pcm_oe);
        etag = etbl[prev_em];
        dtag = dtbl[prev_dm];
        exp_valid = 1'b1;
      end else begin
        exp_valid = 1'b0;
      end
      prev_em = em; prev_dm = dm; prev_sel = s;
      prev_pcm = pcm_in; prev_adp = adpcm_in;
      have_prev = 1;
      exp_core_pcm = pcm_in;
      exp_core_adp = adpcm_in;
      exp_erst = (em == 6);
      exp_drst = (dm == 6);
    end else begin
      exp_valid = 1'b0;
    end
  endtask

  task automatic run_frame(input int em, input int dm, input int s, input int len, input bit jitter);
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      compare();
      drive(c == 0, em, dm, s, jitter);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after reset, no strobe yet
    phase_tag = "R1";
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      compare();
      drive(1'b0, 0, 0, 0, 1'b0);
    end
    phase_tag = "";
    // every encode and decode code with both slot selects
    for (int pass = 0; pass < 2; pass++)
      for (int m = 0; m < 8; m++)
        for (int s = 0; s < 2; s++)
          run_frame(m, (pass == 0) ? (m + 3) % 8 : 7 - m, s, 5, 1'b0);
    // R12: frame-by-frame 32k / 24k switching
    phase_tag = "R12";
    for (int f = 0; f < 10; f++)
      run_frame(f % 2, (f + 1) % 2, int'($urandom % 2), 4, 1'b0);
    // R2: modes and select toggle between strobes
    phase_tag = "R2";
    for (int f = 0; f < 16; f++)
      run_frame(int'($urandom % 8), int'($urandom % 8), int'($urandom % 2), 6, 1'b1);
    phase_tag = "";
    run_frame(0, 0, 0, 4, 1'b0);
    run_frame(0, 0, 0, 4, 1'b0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule